// File: doc/BRIEF.md
# Handshaked Serial Link Host Controller

This block is the host end of a half-duplex, byte-wide serial link to a small peer microcontroller. Three active-low handshake wires pace the link: a request line driven by the peer, and an acknowledge line and a transfer-active line driven by the host. Serialisation is handled elsewhere. The block sees the shift register as a load port, a direction output, and a byte-complete strobe that comes with the captured byte.

After reset the controller runs a two-step synchronisation with the peer. Each wait in that sequence has a timeout. It then takes outbound requests from a small internal queue and shifts their bytes out. The acknowledge line is toggled to pace each byte. If the peer starts talking at the same moment, the controller sees the collision after the first byte and backs off. Replies and unsolicited packets are gathered into a 16-byte buffer. Each finished packet is announced with its length and a reply/unsolicited flag, and the controller can go straight from the end of one incoming packet into the next.

Top module: `hsl_host`

## Requirements
- R1: While reset is held, and until the first clock edge after it is released, `ack_out_n` and `act_out_n` are high, `sr_dir_out` is 0, and `sync_done`, `sync_fail`, `proto_err` and `rx_overflow` are 0.
- R2: On the first edge after reset, `ack_out_n` goes low while `act_out_n` stays high. A byte-complete event with `req_in_n` low then raises `ack_out_n`. A later event with `req_in_n` high sets `sync_done`, and the controller becomes idle.
- R3: If either sync wait sees TICK_CYCLES*TICK_COUNT enabled cycles without its condition, `sync_fail` is set. `ack_out_n` and `act_out_n` are then held high, and no byte is ever loaded.
- R4: A transmission starts only from idle, with a queued request and `req_in_n` high, in a cycle with no byte-complete event. The start pulses `sr_load` with byte 0 of the request, sets `sr_dir_out` to 1 and drives `act_out_n` low.
- R5: A byte-complete event after the first byte with `req_in_n` low is a collision. It clears `sr_dir_out`, drives `ack_out_n` and `act_out_n` high and returns to idle. The request stays queued and is sent again from byte 0 later.
- R6: After each completed byte that is not the last, the next byte is loaded in order 1, 2, ... len-1, and `ack_out_n` is inverted. It therefore reads 0 after byte 0, 1 after byte 1, and so on.
- R7: When the last byte of a request completes, `sr_dir_out` goes to 0 and both outputs go high. A request with `rq_want_reply`=1 then waits for a reply. Otherwise `rq_done` pulses and the request leaves the queue.
- R8: A byte-complete event while idle or while waiting for a reply starts a read. The captured byte is dropped, `act_out_n` goes low, and the packet is marked as a reply only if it began while waiting for one.
- R9: While reading, each event stores `sr_rx_data`. With `req_in_n` low the event inverts `ack_out_n`. With `req_in_n` high the byte is the last one, and both outputs go high.
- R10: The next event after the last byte pulses `pkt_valid` with `pkt_len`, `pkt_is_reply` and the bytes in `pkt_data` (byte k in bits 8k+7:8k). For a reply it also pulses `rq_done`. If `req_in_n` is low at that event, `act_out_n` goes low in the same edge and an unsolicited read begins.
- R11: The buffer holds RX_BYTES (16) bytes. Later bytes of a packet are dropped, `pkt_len` is capped at 16, and the sticky `rx_overflow` is set.
- R12: A read start with `req_in_n` high sets the sticky `proto_err`, and the read still begins.
- R13: The queue holds QUEUE_DEPTH (2) requests. `rq_full` reports a full queue, and a push while full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in_n | input | 1 | Peer request line, active low |
| ack_out_n | output | 1 | Host acknowledge line, active low |
| act_out_n | output | 1 | Host transfer-active line, active low |
| sr_load | output | 1 | One-cycle strobe: load `sr_load_data` into the shift register |
| sr_load_data | output | 8 | Byte to shift out |
| sr_dir_out | output | 1 | Shift direction, 1 = host to peer |
| sr_done | input | 1 | Byte-complete strobe from the shift register |
| sr_rx_data | input | 8 | Byte captured by the shift register |
| rq_push | input | 1 | Enqueue a request |
| rq_bytes | input | MAX_REQ_BYTES*8 | Request bytes, byte k in bits 8k+7:8k |
| rq_len | input | $clog2(MAX_REQ_BYTES+1) | Request length in bytes |
| rq_want_reply | input | 1 | Request expects a reply packet |
| rq_full | output | 1 | Queue full |
| rq_done | output | 1 | One-cycle pulse when the head request is retired |
| pkt_valid | output | 1 | One-cycle pulse: received packet ready |
| pkt_is_reply | output | 1 | Packet is a reply (1) or unsolicited (0) |
| pkt_len | output | $clog2(RX_BYTES+1) | Stored byte count of the packet |
| pkt_data | output | RX_BYTES*8 | Receive buffer contents |
| sync_done | output | 1 | Synchronisation completed |
| sync_fail | output | 1 | Synchronisation timed out |
| rx_overflow | output | 1 | Sticky: a packet exceeded the buffer |
| proto_err | output | 1 | Sticky: unexpected handshake status |

## Verification
The sharpest coincidence is at the end of an incoming packet. If the peer pulls its request line low again at the read-done event, the edge that delivers the old packet's length and flag must also clear the buffer count and start the next read. The bench provokes this by chaining packets with the request line held low, and also with a request waiting in the queue. It checks that the delivered length belongs to the first packet, that the transfer-active line never rises, and that the waiting request does not start until the chained packet ends. A second pairing is collision against read start: after a collision the same queued request must go back to idle and let the peer's packet in before it is retried from byte 0.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

   typedef enum logic [3:0] {
      ST_RST    = 4'd0,
      ST_SYNC_A = 4'd1,
      ST_SYNC_B = 4'd2,
      ST_FAIL   = 4'd3,
      ST_IDLE   = 4'd4,
      ST_SENT1  = 4'd5,
      ST_SEND   = 4'd6,
      ST_AWAIT  = 4'd7,
      ST_READ   = 4'd8,
      ST_RDONE  = 4'd9
   } link_state_e;

endpackage

// File: rtl/hsl_req_fifo.sv
module hsl_req_fifo #(
   parameter int DEPTH = 2,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("hsl_req_fifo: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic         vld_q;
         logic [W-1:0] ent_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               ent_q <= '0;
            end else if (pop && vld_q) begin
               vld_q <= 1'b0;
            end else if (push && !vld_q) begin
               vld_q <= 1'b1;
               ent_q <= din;
            end
         end
         assign dout  = ent_q;
         assign empty = !vld_q;
         assign full  = vld_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);
         logic [W-1:0]  mem_q [DEPTH];
         logic [PW-1:0] wr_q, rd_q;
         logic [CW-1:0] cnt_q;
         logic          do_push, do_pop;

         assign do_push = push && (cnt_q != CW'(DEPTH));
         assign do_pop  = pop && (cnt_q != '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_q  <= '0;
               rd_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (do_push)
                  wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
               if (do_pop)
                  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
               if (do_push && !do_pop)
                  cnt_q <= cnt_q + CW'(1);
               else if (do_pop && !do_push)
                  cnt_q <= cnt_q - CW'(1);
            end
         end

         always_ff @(posedge clk) begin
            if (do_push)
               mem_q[wr_q] <= din;
         end

         assign dout  = mem_q[rd_q];
         assign empty = (cnt_q == '0);
         assign full  = (cnt_q == CW'(DEPTH));
      end
   endgenerate

endmodule

// File: rtl/hsl_sync_timer.sv
module hsl_sync_timer #(
   parameter int TICK_CYCLES = 5000,
   parameter int TICK_COUNT  = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic expired
);

   localparam int TW = $clog2(TICK_CYCLES + 1);
   localparam int NW = $clog2(TICK_COUNT + 1);

   generate
      if (TICK_CYCLES < 1 || TICK_COUNT < 1) begin : g_bad_cfg
         $error("hsl_sync_timer: TICK_CYCLES and TICK_COUNT must be positive");
      end
   endgenerate

   logic [TW-1:0] tick_q;
   logic [NW-1:0] num_q;

   assign expired = (num_q == NW'(TICK_COUNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= '0;
         num_q  <= '0;
      end else if (clr) begin
         tick_q <= '0;
         num_q  <= '0;
      end else if (en && !expired) begin
         if (tick_q == TW'(TICK_CYCLES - 1)) begin
            tick_q <= '0;
            num_q  <= num_q + NW'(1);
         end else begin
            tick_q <= tick_q + TW'(1);
         end
      end
   end

endmodule

// File: rtl/hsl_rx_buf.sv
module hsl_rx_buf #(
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         wr,
   input  logic [7:0]                   din,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic [DEPTH*8-1:0]           data,
   output logic                         ovf
);

   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("hsl_rx_buf: DEPTH must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          is_full;

   assign is_full = (cnt_q == CW'(DEPTH));
   assign ovf     = wr && is_full;
   assign count   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (wr && !is_full)
         cnt_q <= cnt_q + CW'(1);
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [7:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (wr && cnt_q == CW'(g))
            slot_q <= din;
      end
      assign data[g*8 +: 8] = slot_q;
   end

endmodule

// File: rtl/hsl_host.sv
module hsl_host
   import hsl_pkg::*;
#(
   parameter int MAX_REQ_BYTES = 8,
   parameter int QUEUE_DEPTH   = 2,
   parameter int RX_BYTES      = 16,
   parameter int TICK_CYCLES   = 5000,
   parameter int TICK_COUNT    = 1000,
   localparam int LW = $clog2(MAX_REQ_BYTES + 1),
   localparam int PLW = $clog2(RX_BYTES + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_in_n,
   output logic                       ack_out_n,
   output logic                       act_out_n,
   output logic                       sr_load,
   output logic [7:0]                 sr_load_data,
   output logic                       sr_dir_out,
   input  logic                       sr_done,
   input  logic [7:0]                 sr_rx_data,
   input  logic                       rq_push,
   input  logic [MAX_REQ_BYTES*8-1:0] rq_bytes,
   input  logic [LW-1:0]              rq_len,
   input  logic                       rq_want_reply,
   output logic                       rq_full,
   output logic                       rq_done,
   output logic                       pkt_valid,
   output logic                       pkt_is_reply,
   output logic [PLW-1:0]             pkt_len,
   output logic [RX_BYTES*8-1:0]      pkt_data,
   output logic                       sync_done,
   output logic                       sync_fail,
   output logic                       rx_overflow,
   output logic                       proto_err
);

   localparam int QW = MAX_REQ_BYTES * 8 + LW + 1;

   generate
      if (MAX_REQ_BYTES < 1) begin : g_bad_req
         $error("hsl_host: MAX_REQ_BYTES must be at least 1");
      end
   endgenerate

   link_state_e state_q;

   // request queue
   logic [QW-1:0]              q_din, q_dout;
   logic                       q_empty, q_full, q_pop;
   logic [MAX_REQ_BYTES*8-1:0] head_bytes;
   logic [LW-1:0]              head_len;
   logic                       head_want;

   assign q_din      = {rq_want_reply, rq_len, rq_bytes};
   assign head_bytes = q_dout[MAX_REQ_BYTES*8-1:0];
   assign head_len   = q_dout[MAX_REQ_BYTES*8 +: LW];
   assign head_want  = q_dout[QW-1];
   assign rq_full    = q_full;

   hsl_req_fifo #(.DEPTH(QUEUE_DEPTH), .W(QW)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rq_push),
      .din   (q_din),
      .pop   (q_pop),
      .dout  (q_dout),
      .empty (q_empty),
      .full  (q_full)
   );

   // sync timeout
   logic tmr_clr, tmr_en, tmr_exp;

   assign tmr_clr = (state_q == ST_RST) ||
                    (state_q == ST_SYNC_A && !req_in_n && sr_done);
   assign tmr_en  = (state_q == ST_SYNC_A) || (state_q == ST_SYNC_B);

   hsl_sync_timer #(.TICK_CYCLES(TICK_CYCLES), .TICK_COUNT(TICK_COUNT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .en      (tmr_en),
      .expired (tmr_exp)
   );

   // receive buffer
   logic           rx_clr, rx_wr, rx_ovf;
   logic [PLW-1:0] rx_cnt;
   logic           rd_start;

   assign rd_start = sr_done && ((state_q == ST_IDLE) || (state_q == ST_AWAIT) ||
                                 (state_q == ST_RDONE && !req_in_n));
   assign rx_clr   = rd_start;
   assign rx_wr    = sr_done && (state_q == ST_READ);

   hsl_rx_buf #(.DEPTH(RX_BYTES)) u_rxbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rx_clr),
      .wr    (rx_wr),
      .din   (sr_rx_data),
      .count (rx_cnt),
      .data  (pkt_data),
      .ovf   (rx_ovf)
   );

   // transmit byte selection and completion
   logic [LW-1:0] idx_q;
   logic          rep_q;
   logic          in_sent1;
   logic          tx_last;
   logic [LW-1:0] tx_pos;
   logic [7:0]    tx_byte;

   assign in_sent1 = (state_q == ST_SENT1);
   assign tx_pos   = in_sent1 ? LW'(1) : idx_q;
   assign tx_last  = (tx_pos >= head_len);
   assign tx_byte  = 8'(head_bytes >> {tx_pos, 3'b000});

   assign q_pop = sr_done &&
                  ((((in_sent1 && req_in_n) || state_q == ST_SEND) && tx_last && !head_want) ||
                   (state_q == ST_RDONE && rep_q));

   // main sequencer
   logic ack_q, act_q, dir_q, ld_q, pv_q, prep_q, rqd_q;
   logic sdone_q, sfail_q, perr_q, ovf_q;
   logic [7:0]     ld_data_q;
   logic [PLW-1:0] plen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_RST;
         ack_q     <= 1'b1;
         act_q     <= 1'b1;
         dir_q     <= 1'b0;
         ld_q      <= 1'b0;
         ld_data_q <= '0;
         idx_q     <= '0;
         rep_q     <= 1'b0;
         pv_q      <= 1'b0;
         prep_q    <= 1'b0;
         plen_q    <= '0;
         rqd_q     <= 1'b0;
         sdone_q   <= 1'b0;
         sfail_q   <= 1'b0;
         perr_q    <= 1'b0;
         ovf_q     <= 1'b0;
      end else begin
         ld_q  <= 1'b0;
         pv_q  <= 1'b0;
         rqd_q <= q_pop;
         if (rx_ovf)
            ovf_q <= 1'b1;

         unique case (state_q)
            ST_RST: begin
               ack_q   <= 1'b0;
               state_q <= ST_SYNC_A;
            end
            ST_SYNC_A: begin
               if (!req_in_n && sr_done) begin
                  ack_q   <= 1'b1;
                  state_q <= ST_SYNC_B;
               end else if (tmr_exp) begin
                  ack_q   <= 1'b1;
                  sfail_q <= 1'b1;
                  state_q <= ST_FAIL;
               end
            end
            ST_SYNC_B: begin
               if (req_in_n && sr_done) begin
                  act_q   <= 1'b1;
                  sdone_q <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (tmr_exp) begin
                  sfail_q <= 1'b1;
                  state_q <= ST_FAIL;
               end
            end
            ST_FAIL: begin
               ack_q <= 1'b1;
               act_q <= 1'b1;
            end
            ST_IDLE: begin
               if (sr_done) begin
                  if (req_in_n)
                     perr_q <= 1'b1;
                  act_q   <= 1'b0;
                  rep_q   <= 1'b0;
                  state_q <= ST_READ;
               end else if (!q_empty && req_in_n) begin
                  dir_q     <= 1'b1;
                  ld_q      <= 1'b1;
                  ld_data_q <= head_bytes[7:0];
                  act_q     <= 1'b0;
                  state_q   <= ST_SENT1;
               end
            end
            ST_SENT1, ST_SEND: begin
               if (sr_done) begin
                  if (in_sent1 && !req_in_n) begin
                     dir_q   <= 1'b0;
                     act_q   <= 1'b1;
                     ack_q   <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (tx_last) begin
                     dir_q   <= 1'b0;
                     act_q   <= 1'b1;
                     ack_q   <= 1'b1;
                     state_q <= head_want ? ST_AWAIT : ST_IDLE;
                  end else begin
                     ld_q      <= 1'b1;
                     ld_data_q <= tx_byte;
                     ack_q     <= ~ack_q;
                     idx_q     <= tx_pos + LW'(1);
                     state_q   <= ST_SEND;
                  end
               end
            end
            ST_AWAIT: begin
               if (sr_done) begin
                  if (req_in_n)
                     perr_q <= 1'b1;
                  act_q   <= 1'b0;
                  rep_q   <= 1'b1;
                  state_q <= ST_READ;
               end
            end
            ST_READ: begin
               if (sr_done) begin
                  if (req_in_n) begin
                     ack_q   <= 1'b1;
                     act_q   <= 1'b1;
                     state_q <= ST_RDONE;
                  end else begin
                     ack_q <= ~ack_q;
                  end
               end
            end
            ST_RDONE: begin
               if (sr_done) begin
                  pv_q   <= 1'b1;
                  prep_q <= rep_q;
                  plen_q <= rx_cnt;
                  if (!req_in_n) begin
                     act_q   <= 1'b0;
                     rep_q   <= 1'b0;
                     state_q <= ST_READ;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ack_out_n    = ack_q;
   assign act_out_n    = act_q;
   assign sr_dir_out   = dir_q;
   assign sr_load      = ld_q;
   assign sr_load_data = ld_data_q;
   assign rq_done      = rqd_q;
   assign pkt_valid    = pv_q;
   assign pkt_is_reply = prep_q;
   assign pkt_len      = plen_q;
   assign sync_done    = sdone_q;
   assign sync_fail    = sfail_q;
   assign rx_overflow  = ovf_q;
   assign proto_err    = perr_q;

endmodule

// File: rtl/hsl_host_chk.sv
module hsl_host_chk #(
   parameter int PLW      = 5,
   parameter int RX_BYTES = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_in_n,
   input logic           ack_out_n,
   input logic           act_out_n,
   input logic           sr_load,
   input logic           sr_dir_out,
   input logic           sr_done,
   input logic           pkt_valid,
   input logic [PLW-1:0] pkt_len,
   input logic           sync_fail,
   input logic           in_sent1
);

   // R1: first cycle out of reset still shows both lines negated
   a_r1_reset_negated: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ack_out_n && act_out_n && !sr_dir_out));

   // R4: a fresh transmission only starts while the peer request was negated
   a_r4_start_req_negated: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_load && !$past(sr_dir_out)) |-> $past(req_in_n));

   // R5: collision backs off on the following edge
   a_r5_collision_backoff: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sent1 && sr_done && !req_in_n) |=> (!sr_dir_out && act_out_n && ack_out_n));

   // R7: outbound direction is only held while transfer-active is asserted
   a_r7_dir_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
      sr_dir_out |-> !act_out_n);

   // R10: a delivered packet leaves the acknowledge line negated
   a_r10_deliver_ack_high: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> ack_out_n);

   // R11: reported length never exceeds the buffer
   a_r11_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> (pkt_len <= PLW'(RX_BYTES)));

   // R3: after a sync failure the link stays quiet
   a_r3_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sync_fail) |-> (ack_out_n && act_out_n && !sr_load));

endmodule

bind hsl_host hsl_host_chk #(.PLW(PLW), .RX_BYTES(RX_BYTES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_in_n   (req_in_n),
   .ack_out_n  (ack_out_n),
   .act_out_n  (act_out_n),
   .sr_load    (sr_load),
   .sr_dir_out (sr_dir_out),
   .sr_done    (sr_done),
   .pkt_valid  (pkt_valid),
   .pkt_len    (pkt_len),
   .sync_fail  (sync_fail),
   .in_sent1   (in_sent1)
);

// File: tb/sim_hsl_host.sv
module sim_hsl_host;

   localparam int MAXB = 8;
   localparam int QD   = 2;
   localparam int RXB  = 16;
   localparam int LW   = $clog2(MAXB + 1);
   localparam int PLW  = $clog2(RXB + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_in_n = 1'b1;
   logic              ack_out_n, act_out_n, sr_load, sr_dir_out;
   logic [7:0]        sr_load_data;
   logic              sr_done = 1'b0;
   logic [7:0]        sr_rx_data = '0;
   logic              rq_push = 1'b0;
   logic [MAXB*8-1:0] rq_bytes = '0;
   logic [LW-1:0]     rq_len = '0;
   logic              rq_want_reply = 1'b0;
   logic              rq_full, rq_done, pkt_valid, pkt_is_reply;
   logic [PLW-1:0]    pkt_len;
   logic [RXB*8-1:0]  pkt_data;
   logic              sync_done, sync_fail, rx_overflow, proto_err;

   always #10 clk = ~clk;

   hsl_host #(.MAX_REQ_BYTES(MAXB), .QUEUE_DEPTH(QD), .RX_BYTES(RXB),
              .TICK_CYCLES(4), .TICK_COUNT(5)) u0 (.*);

   int checks = 0, failures = 0, cyc = 0;
   int ld_n = 0, ld_seen = 0, pkt_n = 0, rqd_n = 0;
   logic [7:0]       ld_log [0:255];
   logic [PLW-1:0]   got_len;
   logic             got_rep;
   logic [RXB*8-1:0] got_data;
   bit               exp_ovf = 0;

   always @(posedge clk) begin
      #1;
      if (sr_load) begin
         ld_log[ld_n[7:0]] = sr_load_data;
         ld_n++;
      end
      if (pkt_valid) begin
         pkt_n++;
         got_len  = pkt_len;
         got_rep  = pkt_is_reply;
         got_data = pkt_data;
      end
      if (rq_done) rqd_n++;
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         failures++;
         $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int cap_len(input int n);
      return (n > RXB) ? RXB : n;
   endfunction

   function automatic logic exp_ack(input int i);
      return (i % 2 == 0) ? 1'b0 : 1'b1;
   endfunction

   task automatic pulse_done(input logic rn, input logic [7:0] d);
      @(negedge clk);
      req_in_n   = rn;
      sr_rx_data = d;
      sr_done    = 1'b1;
      @(negedge clk);
      sr_done = 1'b0;
   endtask

   task automatic push_req(input logic [MAXB*8-1:0] b, input int n, input bit w);
      @(negedge clk);
      rq_push = 1'b1; rq_bytes = b; rq_len = LW'(n); rq_want_reply = w;
      @(negedge clk);
      rq_push = 1'b0;
   endtask

   task automatic wait_load();
      int t = 0;
      while (ld_n == ld_seen && t < 200) begin
         @(negedge clk);
         t++;
      end
   endtask

   // Serve a transmission already started or about to start.
   task automatic tx_run(input logic [MAXB*8-1:0] b, input int n, input bit w);
      int r0 = rqd_n;
      wait_load();
      chk(ld_n == ld_seen + 1 && ld_log[ld_seen[7:0]] == b[7:0], "R4 byte0 load",
          ld_log[ld_seen[7:0]], b[7:0]);
      chk(sr_dir_out && !act_out_n, "R4 start dir/act", {sr_dir_out, act_out_n}, 2'b10);
      for (int i = 0; i < n; i++) begin
         pulse_done(1'b1, 8'h00);
         if (i < n - 1) begin
            chk(ld_n == ld_seen + i + 2 && ld_log[8'(ld_seen + i + 1)] == b[(i+1)*8 +: 8],
                "R6 next byte order", ld_log[8'(ld_seen + i + 1)], b[(i+1)*8 +: 8]);
            chk(ack_out_n == exp_ack(i), "R6 ack toggle", ack_out_n, exp_ack(i));
         end else begin
            chk(!sr_dir_out && act_out_n && ack_out_n, "R7 end of request",
                {sr_dir_out, act_out_n, ack_out_n}, 3'b011);
            chk(rqd_n == r0 + (w ? 0 : 1), "R7 retire pulse", rqd_n - r0, w ? 0 : 1);
         end
      end
      ld_seen += n;
   endtask

   // Peer sends a packet of n bytes.
   task automatic peer_packet(input int n, input bit is_rep, input bit started,
                              input bit chain);
      logic [7:0] pd [0:31];
      int p0 = pkt_n, r0 = rqd_n;
      for (int i = 0; i < n; i++) pd[i] = 8'($urandom);
      if (!started) begin
         pulse_done(1'b0, 8'hEE);
         chk(!act_out_n, "R8 read start act", act_out_n, 0);
      end
      for (int i = 0; i < n; i++) begin
         pulse_done((i == n - 1) ? 1'b1 : 1'b0, pd[i]);
         if (i < n - 1)
            chk(ack_out_n == exp_ack(i), "R9 read ack toggle", ack_out_n, exp_ack(i));
         else
            chk(ack_out_n && act_out_n, "R9 last byte negates", {ack_out_n, act_out_n}, 2'b11);
      end
      if (n > RXB) exp_ovf = 1;
      pulse_done(chain ? 1'b0 : 1'b1, 8'h5A);
      chk(pkt_n == p0 + 1, "R10 deliver pulse", pkt_n - p0, 1);
      chk(int'(got_len) == cap_len(n), "R11 length cap", got_len, cap_len(n));
      chk(got_rep == is_rep, "R8 reply flag", got_rep, is_rep);
      for (int i = 0; i < cap_len(n); i++)
         chk(got_data[i*8 +: 8] == pd[i], "R9 stored byte", got_data[i*8 +: 8], pd[i]);
      chk(rqd_n == r0 + (is_rep ? 1 : 0), "R10 reply retire", rqd_n - r0, is_rep);
      chk(act_out_n == !chain, "R10 chain act", act_out_n, !chain);
      chk(rx_overflow == exp_ovf, "R11 overflow flag", rx_overflow, exp_ovf);
   endtask

   task automatic do_sync();
      @(negedge clk);
      chk(ack_out_n && act_out_n && !sr_dir_out && !sync_done && !proto_err && !rx_overflow,
          "R1 reset state", {ack_out_n, act_out_n, sr_dir_out}, 3'b110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ack_out_n && act_out_n, "R2 sync ack asserted", {ack_out_n, act_out_n}, 2'b01);
      pulse_done(1'b0, 8'h11);
      chk(ack_out_n, "R2 sync ack released", ack_out_n, 1);
      pulse_done(1'b1, 8'h22);
      chk(sync_done && !sync_fail && act_out_n, "R2 sync complete", sync_done, 1);
   endtask

   function automatic logic [MAXB*8-1:0] rand_bytes();
      logic [MAXB*8-1:0] v;
      for (int i = 0; i < MAXB; i++) v[i*8 +: 8] = 8'($urandom);
      return v;
   endfunction

   initial begin
      logic [MAXB*8-1:0] b, b2, b3;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      do_sync();

      // directed: send without reply, then with reply
      b = rand_bytes();
      push_req(b, 3, 1'b0);
      tx_run(b, 3, 1'b0);
      b = rand_bytes();
      push_req(b, 2, 1'b1);
      tx_run(b, 2, 1'b1);
      peer_packet(4, 1'b1, 1'b0, 1'b0);

      // single-byte request
      b = rand_bytes();
      push_req(b, 1, 1'b0);
      tx_run(b, 1, 1'b0);

      // collision, then peer packet, then retry from byte 0
      b = rand_bytes();
      push_req(b, 3, 1'b0);
      wait_load();
      ld_seen++;
      pulse_done(1'b0, 8'h00);
      chk(!sr_dir_out && act_out_n && ack_out_n, "R5 collision backoff",
          {sr_dir_out, act_out_n, ack_out_n}, 3'b011);
      chk(rqd_n == 0 + rqd_n && ld_n == ld_seen, "R5 no reload during collision", ld_n, ld_seen);
      peer_packet(2, 1'b0, 1'b0, 1'b0);
      tx_run(b, 3, 1'b0);

      // chained packets with a request waiting
      b = rand_bytes();
      req_in_n = 1'b0;
      push_req(b, 2, 1'b0);
      peer_packet(3, 1'b0, 1'b0, 1'b1);
      peer_packet(5, 1'b0, 1'b1, 1'b0);
      chk(ld_n == ld_seen, "R10 queued waits during chain", ld_n, ld_seen);
      tx_run(b, 2, 1'b0);

      // overflow packet
      peer_packet(RXB + 3, 1'b0, 1'b0, 1'b0);

      // queue full: push three while peer holds request
      b = rand_bytes(); b2 = rand_bytes(); b3 = rand_bytes();
      @(negedge clk); req_in_n = 1'b0;
      push_req(b, 2, 1'b0);
      push_req(b2, 3, 1'b0);
      chk(rq_full, "R13 queue full", rq_full, 1);
      push_req(b3, 4, 1'b0);
      chk(ld_n == ld_seen, "R4 no start while req asserted", ld_n, ld_seen);
      @(negedge clk); req_in_n = 1'b1;
      tx_run(b, 2, 1'b0);
      tx_run(b2, 3, 1'b0);
      repeat (10) @(negedge clk);
      chk(ld_n == ld_seen && !rq_full, "R13 third push discarded", ld_n - ld_seen, 0);

      // constrained random mix
      for (int it = 0; it < 40; it++) begin
         int op = $urandom_range(0, 2);
         if (op == 0) begin
            int n = $urandom_range(1, MAXB);
            b = rand_bytes();
            push_req(b, n, 1'b0);
            tx_run(b, n, 1'b0);
         end else if (op == 1) begin
            int n = $urandom_range(1, MAXB);
            b = rand_bytes();
            push_req(b, n, 1'b1);
            tx_run(b, n, 1'b1);
            peer_packet($urandom_range(1, RXB), 1'b1, 1'b0, 1'b0);
         end else begin
            peer_packet($urandom_range(1, RXB + 4), 1'b0, 1'b0, 1'b0);
         end
      end

      // protocol error: event in idle with request negated
      chk(!proto_err, "R12 no error before", proto_err, 0);
      pulse_done(1'b1, 8'h33);
      chk(proto_err && !act_out_n, "R12 error but read starts", {proto_err, act_out_n}, 2'b10);
      peer_packet(1, 1'b0, 1'b1, 1'b0);

      // sync timeout
      @(negedge clk); rst_n = 1'b0; req_in_n = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      chk(sync_fail && !sync_done && ack_out_n && act_out_n, "R3 sync timeout",
          {sync_fail, sync_done, ack_out_n, act_out_n}, 4'b1011);
      b = rand_bytes();
      push_req(b, 2, 1'b0);
      repeat (10) @(negedge clk);
      chk(ld_n == ld_seen, "R3 no load after failure", ld_n, ld_seen);

      summary();
      $finish;
   end

endmodule